// File: doc/BRIEF.md
# Message-Driven Counting Semaphore

This block is a counting semaphore that occupies one address on a message bus. Other agents send it messages that either return units to it or ask for units from it. The data field of each message gives the number of units. When a request can be met, the semaphore subtracts the units and sends an acknowledge message back to the requester's address. If the request cannot be met, it stays parked with no reply until enough units come back.

Parked requests are kept in a small table with one slot per requester address. Whenever the count allows, the semaphore wakes them. A request from the processor's address always goes first. After that, the request that has waited longest goes first. The outbound side holds a single message and presents it to the bus arbiter with a request line. The message stays on the outputs until the arbiter grants it. The maximum count, the starting count, the block's own address and the processor's address are parameters.

Top module: `msg_semaphore`

## Requirements
- R1: After reset the count equals INIT_COUNT (default 4), no request is parked, and `outReq` is low.
- R2: A give message (op code 3'd1) raises the count by the data field. A take message (op code 3'd2) that is granted lowers the count by the data field.
- R3: A give that would take the count past MAX_COUNT (default 12) leaves the count at MAX_COUNT.
- R4: A take whose amount does not exceed the current count, arriving while the outbound slot is free or being granted, raises `outReq` at the next clock edge. The outbound message then carries `outDst` equal to the requester's `inSrc`, `outSrc` equal to MY_ADDR (default 9), `outOp` equal to 3'd5 (acknowledge), and `outData` equal to the amount.
- R5: Messages whose `inDst` differs from MY_ADDR, and messages with any op code other than 3'd1 or 3'd2, leave the count and the parked requests unchanged.
- R6: A take that exceeds the current count produces no acknowledge and stays parked until gives make it fit.
- R7: Among parked requests that fit the count, the one from CPU_ADDR (default 0) is acknowledged first.
- R8: Among parked requests that fit and do not come from CPU_ADDR, the one that has been parked longest is acknowledged first.
- R9: At most one acknowledge is issued per cycle. Further parked requests are served on following cycles, each only while it still fits the remaining count.
- R10: While `outReq` is high and `outGrant` is low, the outbound message fields stay unchanged and no new acknowledge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An inbound message is present this cycle |
| inDst | input | 4 | Inbound destination address |
| inSrc | input | 4 | Inbound sender address |
| inOp | input | 3 | Inbound op code |
| inData | input | 32 | Inbound unit count |
| outGrant | input | 1 | The arbiter accepts the outbound message this cycle |
| outReq | output | 1 | The outbound message is waiting for the bus |
| outDst | output | 4 | Outbound destination (requester) |
| outSrc | output | 4 | Outbound sender (MY_ADDR) |
| outOp | output | 3 | Outbound op code (acknowledge) |
| outData | output | 32 | Units granted |

## Verification
Two pairs of events can land on the same edge. The first pair is a give arriving in the cycle that a parked request is served. The bench checks that the give's units cannot be spent by a waiter before the next cycle. The second pair is a fresh take arriving while a previous acknowledge is still held by a low `outGrant`. The bench withholds the grant for several cycles and confirms that the held message stays frozen. It then confirms that the parked take is acknowledged on the edge where the grant comes back. Ordering is judged by parking a processor request alongside an older ordinary request, and by parking two ordinary requests whose indices run against their arrival order. The expected acknowledge sequence for each case is derived by hand.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_GIVE  = 3'd1,
    OP_TAKE  = 3'd2,
    OP_START = 3'd3,
    OP_STOP  = 3'd4,
    OP_ACK   = 3'd5
  } sem_op_e;

  typedef struct packed {
    logic              issue;
    logic              fromIn;
    logic [ADDR_W-1:0] ackDst;
    logic [DATA_W-1:0] takeAmt;
    logic              storeIn;
    logic              give;
  } sem_strobe_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int MY_ADDR  = 9,
  parameter int CPU_ADDR = 0,
  parameter int CNT_W    = 4,
  parameter int AGE_W    = 8,
  parameter int NUM_REQ  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inDst,
  input  logic [ADDR_W-1:0] inSrc,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]  count,
  input  logic              pendValid [NUM_REQ],
  input  logic [DATA_W-1:0] pendAmt   [NUM_REQ],
  input  logic [AGE_W-1:0]  pendAge   [NUM_REQ],
  input  logic              outReq,
  input  logic              outGrant,
  output sem_strobe_t       strb
);
  localparam logic [ADDR_W-1:0] CPU_IDX = ADDR_W'(CPU_ADDR);
  localparam logic [ADDR_W-1:0] ME      = ADDR_W'(MY_ADDR);

  logic [DATA_W-1:0]  countExt;
  logic [NUM_REQ-1:0] fit;
  logic               inTake, inGive, inFit;
  logic               oldFound, haveWin, winIn, slotFree;
  logic [ADDR_W-1:0]  oldIdx, winIdx;
  logic [AGE_W-1:0]   oldAge;

  assign countExt = DATA_W'(count);

  always_comb begin
    inTake = inValid && (inDst == ME) && (inOp == OP_TAKE);
    inGive = inValid && (inDst == ME) && (inOp == OP_GIVE);
    inFit  = inTake && (inData <= countExt);
    for (int i = 0; i < NUM_REQ; i++) begin
      fit[i] = pendValid[i] && (pendAmt[i] <= countExt);
    end
    // oldest fitting waiter, lowest index on equal age
    oldFound = 1'b0;
    oldIdx   = '0;
    oldAge   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (fit[i] && (!oldFound || pendAge[i] > oldAge)) begin
        oldFound = 1'b1;
        oldIdx   = ADDR_W'(i);
        oldAge   = pendAge[i];
      end
    end
    haveWin = 1'b1;
    winIn   = 1'b0;
    winIdx  = oldIdx;
    if (fit[CPU_IDX]) begin
      winIdx = CPU_IDX;
    end else if (inFit && inSrc == CPU_IDX) begin
      winIn = 1'b1;
    end else if (oldFound) begin
      winIdx = oldIdx;
    end else if (inFit) begin
      winIn = 1'b1;
    end else begin
      haveWin = 1'b0;
    end
    slotFree     = !outReq || outGrant;
    strb.issue   = slotFree && haveWin;
    strb.fromIn  = winIn;
    strb.ackDst  = winIn ? inSrc : winIdx;
    strb.takeAmt = winIn ? inData : pendAmt[winIdx];
    strb.storeIn = inTake && !(strb.issue && winIn);
    strb.give    = inGive;
  end

  // R6
  issue_fits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (strb.takeAmt <= countExt));

  // R7
  cpu_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && pendValid[CPU_IDX] && pendAmt[CPU_IDX] <= countExt) |-> (strb.ackDst == CPU_IDX));

  // R10
  busy_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && !outGrant) |-> !strb.issue);
endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int MY_ADDR    = 9,
  parameter int MAX_COUNT  = 12,
  parameter int INIT_COUNT = 4,
  parameter int CNT_W      = 4,
  parameter int AGE_W      = 8,
  parameter int NUM_REQ    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sem_strobe_t       strb,
  input  logic [ADDR_W-1:0] inSrc,
  input  logic [DATA_W-1:0] inData,
  input  logic              outGrant,
  output logic [CNT_W-1:0]  count,
  output logic              pendValid [NUM_REQ],
  output logic [DATA_W-1:0] pendAmt   [NUM_REQ],
  output logic [AGE_W-1:0]  pendAge   [NUM_REQ],
  output logic              outReq,
  output logic [ADDR_W-1:0] outDst,
  output logic [ADDR_W-1:0] outSrc,
  output logic [OP_W-1:0]   outOp,
  output logic [DATA_W-1:0] outData
);
  localparam logic [DATA_W:0]  MAX_WIDE = (DATA_W+1)'(MAX_COUNT);
  localparam logic [CNT_W-1:0] MAX_C    = CNT_W'(MAX_COUNT);
  localparam logic [CNT_W-1:0] INIT_C   = CNT_W'(INIT_COUNT);
  localparam logic [AGE_W-1:0] AGE_TOP  = '1;

  logic [DATA_W:0]  afterTake, afterGive;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    afterTake = {{(DATA_W+1-CNT_W){1'b0}}, count} - (strb.issue ? {1'b0, strb.takeAmt} : '0);
    afterGive = afterTake + (strb.give ? {1'b0, inData} : '0);
    countNext = (afterGive > MAX_WIDE) ? MAX_C : afterGive[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= INIT_C;
    else       count <= countNext;
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendValid[g] <= 1'b0;
        pendAmt[g]   <= '0;
        pendAge[g]   <= '0;
      end else if (strb.storeIn && inSrc == ADDR_W'(g)) begin
        pendValid[g] <= 1'b1;
        pendAmt[g]   <= inData;
        pendAge[g]   <= '0;
      end else if (strb.issue && !strb.fromIn && strb.ackDst == ADDR_W'(g)) begin
        pendValid[g] <= 1'b0;
      end else if (pendValid[g] && pendAge[g] != AGE_TOP) begin
        pendAge[g] <= pendAge[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReq  <= 1'b0;
      outDst  <= '0;
      outSrc  <= '0;
      outOp   <= OP_NONE;
      outData <= '0;
    end else if (strb.issue) begin
      outReq  <= 1'b1;
      outDst  <= strb.ackDst;
      outSrc  <= ADDR_W'(MY_ADDR);
      outOp   <= OP_ACK;
      outData <= strb.takeAmt;
    end else if (outGrant) begin
      outReq  <= 1'b0;
    end
  end

  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= MAX_C);

  // R4
  ack_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReq |-> (outOp == OP_ACK && outSrc == ADDR_W'(MY_ADDR)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && !outGrant) |=> (outReq && $stable(outDst) && $stable(outData)));
endmodule

// File: rtl/msg_semaphore.sv
module msg_semaphore
  import sem_pkg::*;
#(
  parameter int MY_ADDR    = 9,
  parameter int CPU_ADDR   = 0,
  parameter int MAX_COUNT  = 12,
  parameter int INIT_COUNT = 4,
  parameter int AGE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inDst,
  input  logic [ADDR_W-1:0] inSrc,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inData,
  input  logic              outGrant,
  output logic              outReq,
  output logic [ADDR_W-1:0] outDst,
  output logic [ADDR_W-1:0] outSrc,
  output logic [OP_W-1:0]   outOp,
  output logic [DATA_W-1:0] outData
);
  localparam int CNT_W   = $clog2(MAX_COUNT + 1);
  localparam int NUM_REQ = 1 << ADDR_W;

  sem_strobe_t       strb;
  logic [CNT_W-1:0]  count;
  logic              pendValid [NUM_REQ];
  logic [DATA_W-1:0] pendAmt   [NUM_REQ];
  logic [AGE_W-1:0]  pendAge   [NUM_REQ];

  sem_ctrl #(
    .MY_ADDR(MY_ADDR), .CPU_ADDR(CPU_ADDR), .CNT_W(CNT_W),
    .AGE_W(AGE_W), .NUM_REQ(NUM_REQ)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDst(inDst), .inSrc(inSrc),
    .inOp(inOp), .inData(inData), .count(count), .pendValid(pendValid),
    .pendAmt(pendAmt), .pendAge(pendAge), .outReq(outReq),
    .outGrant(outGrant), .strb(strb)
  );

  sem_datapath #(
    .MY_ADDR(MY_ADDR), .MAX_COUNT(MAX_COUNT), .INIT_COUNT(INIT_COUNT),
    .CNT_W(CNT_W), .AGE_W(AGE_W), .NUM_REQ(NUM_REQ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inSrc(inSrc), .inData(inData),
    .outGrant(outGrant), .count(count), .pendValid(pendValid),
    .pendAmt(pendAmt), .pendAge(pendAge), .outReq(outReq), .outDst(outDst),
    .outSrc(outSrc), .outOp(outOp), .outData(outData)
  );
endmodule

// File: tb/msg_semaphore_bench.sv
module msg_semaphore_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  inDst = '0, inSrc = '0;
  logic [2:0]  inOp = '0;
  logic [31:0] inData = '0;
  logic        outGrant = 1'b1;
  logic        outReq;
  logic [3:0]  outDst, outSrc;
  logic [2:0]  outOp;
  logic [31:0] outData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  msg_semaphore u_msg_semaphore (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDst(inDst), .inSrc(inSrc),
    .inOp(inOp), .inData(inData), .outGrant(outGrant), .outReq(outReq),
    .outDst(outDst), .outSrc(outSrc), .outOp(outOp), .outData(outData)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [3:0] src;
    logic [3:0] dst;
    logic [7:0] data;
    logic       expReq;
    logic [3:0] expDst;
    logic [7:0] expData;
    logic [3:0] req;
  } vec_t;

  // op: 0 idle, 1 give, 2 take, 4 other; semaphore address 9, cpu 0
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 4'd3, 4'd9, 8'd3,  1'b1, 4'd3,  8'd3,  4'd4}, // R4 R1 direct take, count 4->1
    '{3'd2, 4'd4, 4'd9, 8'd2,  1'b0, 4'd0,  8'd0,  4'd6}, // R6 parks
    '{3'd1, 4'd5, 4'd9, 8'd1,  1'b0, 4'd0,  8'd0,  4'd2}, // R2 give lands same edge, no wake yet
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd4,  8'd2,  4'd6}, // R6 waiter woken, count 0
    '{3'd1, 4'd5, 4'd7, 8'd5,  1'b0, 4'd0,  8'd0,  4'd5}, // R5 wrong address
    '{3'd4, 4'd6, 4'd9, 8'd1,  1'b0, 4'd0,  8'd0,  4'd5}, // R5 other op
    '{3'd2, 4'd6, 4'd9, 8'd1,  1'b0, 4'd0,  8'd0,  4'd5}, // R5 count still 0
    '{3'd1, 4'd5, 4'd9, 8'd20, 1'b0, 4'd0,  8'd0,  4'd3}, // R3 saturate to 12
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd6,  8'd1,  4'd2}, // R2 count 11
    '{3'd2, 4'd7, 4'd9, 8'd11, 1'b1, 4'd7,  8'd11, 4'd3}, // R3 exactly 11 left
    '{3'd2, 4'd8, 4'd9, 8'd12, 1'b0, 4'd0,  8'd0,  4'd6},
    '{3'd2, 4'd1, 4'd9, 8'd1,  1'b0, 4'd0,  8'd0,  4'd6},
    '{3'd2, 4'd0, 4'd9, 8'd5,  1'b0, 4'd0,  8'd0,  4'd7},
    '{3'd1, 4'd5, 4'd9, 8'd13, 1'b0, 4'd0,  8'd0,  4'd3}, // saturate 12
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd0,  8'd5,  4'd7}, // R7 cpu first, count 7
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd1,  8'd1,  4'd9}, // R9 next, count 6
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b0, 4'd0,  8'd0,  4'd9}, // R9 12 does not fit 6
    '{3'd1, 4'd5, 4'd9, 8'd6,  1'b0, 4'd0,  8'd0,  4'd2},
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd8,  8'd12, 4'd2},
    '{3'd2, 4'd10,4'd9, 8'd2,  1'b0, 4'd0,  8'd0,  4'd8},
    '{3'd2, 4'd2, 4'd9, 8'd2,  1'b0, 4'd0,  8'd0,  4'd8},
    '{3'd1, 4'd5, 4'd9, 8'd4,  1'b0, 4'd0,  8'd0,  4'd8},
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd10, 8'd2,  4'd8}, // R8 older, higher index
    '{3'd0, 4'd0, 4'd0, 8'd0,  1'b1, 4'd2,  8'd2,  4'd9}  // R9 remaining one
  };

  task automatic checkOut(input int req, input logic eReq, input logic [3:0] eDst,
                          input logic [31:0] eData, input string tag);
    checks++;
    if (outReq !== eReq || (eReq && (outDst !== eDst || outData !== eData ||
        outOp !== 3'd5 || outSrc !== 4'd9))) begin
      failures++;
      $display("FAIL R%0d %s: req=%0b dst=%0d data=%0d op=%0d src=%0d expected req=%0b dst=%0d data=%0d op=5 src=9",
               req, tag, outReq, outDst, outData, outOp, outSrc, eReq, eDst, eData);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [3:0] src,
                       input logic [3:0] dst, input logic [31:0] data);
    @(negedge clk);
    inValid = (op != 3'd0);
    inOp = op; inSrc = src; inDst = dst; inData = data;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; inOp = '0;
    @(posedge clk); @(posedge clk);
    #1;
    checkOut(1, 1'b0, 4'd0, 32'd0, "R1 reset");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].src, VECS[i].dst, 32'(VECS[i].data));
      checkOut(int'(VECS[i].req), VECS[i].expReq, VECS[i].expDst,
               32'(VECS[i].expData), $sformatf("vec %0d", i));
    end
    // R10 arbiter stall with a take arriving during the stall
    doReset();
    outGrant = 1'b0;
    drive(3'd2, 4'd3, 4'd9, 32'd1);
    checkOut(4, 1'b1, 4'd3, 32'd1, "R4 after reset");
    drive(3'd2, 4'd5, 4'd9, 32'd1);
    checkOut(10, 1'b1, 4'd3, 32'd1, "R10 held with take");
    drive(3'd0, 4'd0, 4'd0, 32'd0);
    checkOut(10, 1'b1, 4'd3, 32'd1, "R10 held idle");
    outGrant = 1'b1;
    drive(3'd0, 4'd0, 4'd0, 32'd0);
    checkOut(9, 1'b1, 4'd5, 32'd1, "R9 served on grant edge");
    drive(3'd0, 4'd0, 4'd0, 32'd0);
    checkOut(10, 1'b0, 4'd0, 32'd0, "R10 released");
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule